// File: doc/BRIEF.md
# Embedded Timing Reference Decoder

This block watches an interleaved 4:2:2 video word stream, one word per video clock (27 MHz nominal), for the timing codes that mark the start and end of active video. A timing code is three preamble words (all ones, then zero, then zero) followed by a status word. The upper eight bits of the status word carry a fixed one, the field bit F, the vertical blanking bit V, the horizontal bit H (zero for start of active video, one for end of active video) and four protection bits. The decoder checks the protection bits. It repairs any single flipped bit. When the protection bits show more than one bit in error, it stops relying on them and takes F, V and H as received.

The decoder keeps F, V and H on its outputs between codes. It pulses a strobe for every code it accepts and separate strobes for a repaired code, an unrepairable code and a malformed status word. A mode input selects between the embedded codes and three external sync pins. In external mode the word stream has no effect and the flags follow the pins. The word width is a parameter; wider streams use their top eight bits for the status field. A second parameter can turn off single-bit repair.

Top module: `tref_decoder`

## Requirements
- R1: In embedded mode, `code_stb_o` pulses for exactly one cycle, registered one clock after a status word whose MSB is 1 and whose three preceding words were all ones, all zeros and all zeros (oldest first). Overlapping runs such as ones, ones, zero, zero, status are recognised.
- R2: In the status word, bit 7 is the fixed one, bit 6 is F, bit 5 is V and bit 4 is H. Bits 3..0 are protection bits equal to V^H, F^H, F^V and F^V^H. A status word that matches these is accepted with F, V and H shown on `fld_o`, `vbl_o` and `hflag_o`, and no repair or error strobe.
- R3: With repair enabled (CORRECT_EN=1), a single flipped F, V or H bit is corrected on the flag outputs, and `fix_stb_o` pulses together with `code_stb_o`.
- R4: With repair enabled, a single flipped protection bit leaves the received F, V and H on the outputs, and `fix_stb_o` pulses together with `code_stb_o`.
- R5: A status word that is not within one bit of a valid code word pulses `err_stb_o` with `code_stb_o`, and the outputs take F, V and H directly from the received bits.
- R6: A status word with MSB 0 after a valid preamble pulses `bad_stb_o` and not `code_stb_o`, and leaves the flag outputs unchanged.
- R7: In embedded mode, the flag outputs change only in a cycle in which `code_stb_o` is high.
- R8: In external mode (`embed_sel`=0), the flag outputs equal `ext_f`, `ext_v` and `ext_h` sampled one clock earlier. The word stream is ignored and no strobe pulses.
- R9: During and right after reset, all flag and strobe outputs are 0.
- R10: At most one of `fix_stb_o`, `err_stb_o` and `bad_stb_o` is high in any cycle.
- R11: With repair disabled (CORRECT_EN=0), every status word that does not match exactly is reported through `err_stb_o` with the received flags, and `fix_stb_o` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| embed_sel | input | 1 | 1 selects embedded timing codes, 0 selects the external pins |
| ext_f | input | 1 | External field pin |
| ext_v | input | 1 | External vertical blanking pin |
| ext_h | input | 1 | External horizontal pin |
| vid_in | input | DATA_W | Video word stream |
| fld_o | output | 1 | Field flag F |
| vbl_o | output | 1 | Vertical blanking flag V |
| hflag_o | output | 1 | Horizontal flag H (1 = end of active video) |
| code_stb_o | output | 1 | Timing code accepted |
| fix_stb_o | output | 1 | Accepted code had one bit repaired |
| err_stb_o | output | 1 | Accepted code had an unrepairable error |
| bad_stb_o | output | 1 | Status word after a preamble had MSB 0 |

## Verification
The bound checker checks on every cycle the properties that hold at every clock edge. These are the exclusivity of the three status strobes, that a code strobe comes only after the right preamble words, that flags hold between codes, that a clean code copies its received bits, and that the flags follow the external pins in external mode. Only the bench scenarios can show that the repair picks the right bit for each single-error position and that multi-bit errors fall back to the raw bits. The same holds for the no-repair variant, overlapping preambles and the return from external mode. For these, a model in the bench searches for the nearest valid code word and predicts the result.

// File: rtl/tref_pkg.sv
package tref_pkg;

   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } tref_flags_t;

   typedef enum logic [1:0] {
      CHK_CLEAN  = 2'd0,
      CHK_FIXED  = 2'd1,
      CHK_BROKEN = 2'd2
   } chk_res_t;

   // protection nibble for a flag triple, ordered P3..P0
   function automatic logic [3:0] tref_prot(input tref_flags_t x);
      return {x.v ^ x.h, x.f ^ x.h, x.f ^ x.v, x.f ^ x.v ^ x.h};
   endfunction

endpackage

// File: rtl/tref_preamble.sv
module tref_preamble #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic              hit
);
   localparam int HIST = 3;

   logic [DATA_W-1:0] hist_q [HIST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
      end else begin
         hist_q[0] <= din;
         for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
      end
   end

   // oldest word all ones, then a run of zero words
   logic zeros_ok;
   always_comb begin
      zeros_ok = 1'b1;
      for (int i = 0; i < HIST-1; i++)
         if (hist_q[i] != '0) zeros_ok = 1'b0;
   end

   assign hit = (&hist_q[HIST-1]) && zeros_ok;

endmodule

// File: rtl/tref_protect.sv
module tref_protect
   import tref_pkg::*;
#(
   parameter bit CORRECT_EN = 1'b1
) (
   input  logic [6:0]  bits_i,
   output tref_flags_t flags_o,
   output chk_res_t    res_o
);
   tref_flags_t rx;
   logic [3:0]  syn;

   assign rx  = tref_flags_t'(bits_i[6:4]);
   assign syn = bits_i[3:0] ^ tref_prot(rx);

   generate
      if (CORRECT_EN) begin : g_fix
         always_comb begin
            flags_o = rx;
            res_o   = CHK_FIXED;
            unique case (syn)
               4'b0000: res_o = CHK_CLEAN;
               4'b0111: flags_o.f = ~rx.f;
               4'b1011: flags_o.v = ~rx.v;
               4'b1101: flags_o.h = ~rx.h;
               4'b1000, 4'b0100, 4'b0010, 4'b0001: res_o = CHK_FIXED;
               default: res_o = CHK_BROKEN;
            endcase
         end
      end else begin : g_nofix
         always_comb begin
            flags_o = rx;
            res_o   = (syn == 4'b0000) ? CHK_CLEAN : CHK_BROKEN;
         end
      end
   endgenerate

endmodule

// File: rtl/tref_decoder.sv
module tref_decoder
   import tref_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit CORRECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              embed_sel,
   input  logic              ext_f,
   input  logic              ext_v,
   input  logic              ext_h,
   input  logic [DATA_W-1:0] vid_in,
   output logic              fld_o,
   output logic              vbl_o,
   output logic              hflag_o,
   output logic              code_stb_o,
   output logic              fix_stb_o,
   output logic              err_stb_o,
   output logic              bad_stb_o
);
   localparam int STAT_LSB = DATA_W - 8;

   generate
      if (DATA_W < 8) begin : g_width_chk
         $error("tref_decoder: DATA_W must be at least 8");
      end
   endgenerate

   logic        pre_hit;
   logic [7:0]  stat;
   tref_flags_t dec_flags;
   chk_res_t    dec_res;
   tref_flags_t flags_q;

   assign stat = vid_in[STAT_LSB +: 8];

   tref_preamble #(.DATA_W(DATA_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (vid_in),
      .hit   (pre_hit)
   );

   tref_protect #(.CORRECT_EN(CORRECT_EN)) u_prot (
      .bits_i  (stat[6:0]),
      .flags_o (dec_flags),
      .res_o   (dec_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q    <= '0;
         code_stb_o <= 1'b0;
         fix_stb_o  <= 1'b0;
         err_stb_o  <= 1'b0;
         bad_stb_o  <= 1'b0;
      end else begin
         code_stb_o <= 1'b0;
         fix_stb_o  <= 1'b0;
         err_stb_o  <= 1'b0;
         bad_stb_o  <= 1'b0;
         if (!embed_sel) begin
            flags_q <= '{f: ext_f, v: ext_v, h: ext_h};
         end else if (pre_hit) begin
            if (stat[7]) begin
               flags_q    <= dec_flags;
               code_stb_o <= 1'b1;
               fix_stb_o  <= (dec_res == CHK_FIXED);
               err_stb_o  <= (dec_res == CHK_BROKEN);
            end else begin
               bad_stb_o  <= 1'b1;
            end
         end
      end
   end

   assign fld_o   = flags_q.f;
   assign vbl_o   = flags_q.v;
   assign hflag_o = flags_q.h;

endmodule

// File: rtl/tref_decoder_chk.sv
module tref_decoder_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              embed_sel,
   input logic              ext_f,
   input logic              ext_v,
   input logic              ext_h,
   input logic [DATA_W-1:0] vid_in,
   input logic              fld_o,
   input logic              vbl_o,
   input logic              hflag_o,
   input logic              code_stb_o,
   input logic              fix_stb_o,
   input logic              err_stb_o,
   input logic              bad_stb_o
);
   logic alive_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alive_q <= 1'b0;
      else        alive_q <= 1'b1;
   end

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fix_stb_o, err_stb_o, bad_stb_o}));

   // R6
   bad_no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_stb_o |-> !code_stb_o);

   // R3
   fix_with_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fix_stb_o |-> code_stb_o);

   // R5
   err_with_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_stb_o |-> code_stb_o);

   // R1
   code_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_stb_o |-> ($past(vid_in, 4) == {DATA_W{1'b1}} &&
                      $past(vid_in, 3) == '0 &&
                      $past(vid_in, 2) == '0 &&
                      $past(vid_in[DATA_W-1], 1)));

   // R2
   clean_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_stb_o && !fix_stb_o && !err_stb_o) |->
         ({fld_o, vbl_o, hflag_o} == $past(vid_in[DATA_W-2 -: 3], 1)));

   // R7
   hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alive_q && embed_sel && $past(embed_sel) && !code_stb_o) |->
         $stable({fld_o, vbl_o, hflag_o}));

   // R8
   ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alive_q && !$past(embed_sel)) |->
         ({fld_o, vbl_o, hflag_o} == $past({ext_f, ext_v, ext_h})));

   // R8
   ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alive_q && !$past(embed_sel)) |-> !(code_stb_o || bad_stb_o));

endmodule

bind tref_decoder tref_decoder_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .embed_sel  (embed_sel),
   .ext_f      (ext_f),
   .ext_v      (ext_v),
   .ext_h      (ext_h),
   .vid_in     (vid_in),
   .fld_o      (fld_o),
   .vbl_o      (vbl_o),
   .hflag_o    (hflag_o),
   .code_stb_o (code_stb_o),
   .fix_stb_o  (fix_stb_o),
   .err_stb_o  (err_stb_o),
   .bad_stb_o  (bad_stb_o)
);

// File: tb/tref_decoder_test.sv
module tref_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       embed_sel = 1'b1;
   logic       ext_f = 1'b0, ext_v = 1'b0, ext_h = 1'b0;
   logic [7:0] vid_in = 8'h10;

   logic f1, v1, h1, c1, x1, e1, b1;
   logic f2, v2, h2, c2, x2, e2, b2;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [2:0] prev1 = 3'b000;
   logic [2:0] prev2 = 3'b000;

   always #5 clk = ~clk;

   tref_decoder #(.DATA_W(8), .CORRECT_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .embed_sel(embed_sel),
      .ext_f(ext_f), .ext_v(ext_v), .ext_h(ext_h), .vid_in(vid_in),
      .fld_o(f1), .vbl_o(v1), .hflag_o(h1), .code_stb_o(c1),
      .fix_stb_o(x1), .err_stb_o(e1), .bad_stb_o(b1));

   tref_decoder #(.DATA_W(8), .CORRECT_EN(1'b0)) uut_nc (
      .clk(clk), .rst_n(rst_n), .embed_sel(embed_sel),
      .ext_f(ext_f), .ext_v(ext_v), .ext_h(ext_h), .vid_in(vid_in),
      .fld_o(f2), .vbl_o(v2), .hflag_o(h2), .code_stb_o(c2),
      .fix_stb_o(x2), .err_stb_o(e2), .bad_stb_o(b2));

   // result vector {code, fix, err, bad, f, v, h}
   function automatic logic [6:0] model(input logic [7:0] st, input bit corr_en,
                                        input logic [2:0] prev);
      logic [6:0] cw;
      int         best_d;
      logic [2:0] best_c;
      best_d = 8;
      best_c = 3'b000;
      if (!st[7]) return {4'b0001, prev};
      for (int c = 0; c < 8; c++) begin
         logic f, v, h;
         f = c[2]; v = c[1]; h = c[0];
         cw = {f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
         if ($countones(cw ^ st[6:0]) < best_d) begin
            best_d = $countones(cw ^ st[6:0]);
            best_c = c[2:0];
         end
      end
      if (best_d == 0) return {4'b1000, best_c};
      if (best_d == 1 && corr_en) return {4'b1100, best_c};
      return {4'b1010, st[6:4]};
   endfunction

   function automatic logic [7:0] mk_stat(input logic [2:0] fvh);
      logic f, v, h;
      f = fvh[2]; v = fvh[1]; h = fvh[0];
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      vid_in = b;
      @(posedge clk);
      #2;
   endtask

   task automatic send_code(input string req, input logic [7:0] st);
      logic [6:0] e1v, e2v;
      push(8'hFF); push(8'h00); push(8'h00);
      push(st);
      e1v = model(st, 1'b1, prev1);
      e2v = model(st, 1'b0, prev2);
      check(req, {c1, x1, e1, b1, f1, v1, h1}, e1v);
      check({req, " R11"}, {c2, x2, e2, b2, f2, v2, h2}, e2v);
      prev1 = e1v[2:0];
      prev2 = e2v[2:0];
      // R1 R7: strobe lasts one cycle, flags hold on a filler word
      push(8'h01 + 8'($urandom % 254));
      check({req, " R1 R7 after"}, {c1, x1, e1, b1, f1, v1, h1}, {4'b0000, prev1});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #2;
      // R9: reset state
      check("R9 reset", {c1, x1, e1, b1, f1, v1, h1}, 7'b0);
      rst_n = 1'b1;
      push(8'h10);
      check("R9 after reset", {c1, x1, e1, b1, f1, v1, h1}, 7'b0);

      // R2: every clean code
      for (int k = 0; k < 8; k++) send_code("R2 clean", mk_stat(k[2:0]));
      // R3: single errors in F, V, H
      send_code("R3 F flip", mk_stat(3'b010) ^ 8'h40);
      send_code("R3 V flip", mk_stat(3'b101) ^ 8'h20);
      send_code("R3 H flip", mk_stat(3'b000) ^ 8'h10);
      // R4: single errors in protection bits
      send_code("R4 P3 flip", mk_stat(3'b011) ^ 8'h08);
      send_code("R4 P0 flip", mk_stat(3'b110) ^ 8'h01);
      // R5: double errors
      send_code("R5 F+V flip", mk_stat(3'b001) ^ 8'h60);
      send_code("R5 P2+P1 flip", mk_stat(3'b111) ^ 8'h06);
      // R6: malformed status keeps flags
      send_code("R6 msb zero", mk_stat(3'b100) & 8'h7F);

      // R1: overlapping preamble ones, ones, zero, zero, status
      push(8'hFF);
      send_code("R1 overlap", mk_stat(3'b101));
      // R1: broken preamble is not a code
      push(8'hFF); push(8'h00); push(8'h05); push(mk_stat(3'b010));
      check("R1 broken preamble", {c1, x1, e1, b1, f1, v1, h1}, {4'b0000, prev1});

      // R8: external mode ignores the stream
      embed_sel = 1'b0;
      for (int k = 0; k < 6; k++) begin
         {ext_f, ext_v, ext_h} = 3'($urandom);
         push(k[0] ? 8'hFF : 8'h00);
         check("R8 ext follow", {c1, x1, e1, b1, f1, v1, h1}, {4'b0000, ext_f, ext_v, ext_h});
      end
      {ext_f, ext_v, ext_h} = 3'b101;
      push(8'hFF); push(8'h00); push(8'h00); push(mk_stat(3'b010));
      check("R8 code ignored", {c1, x1, e1, b1, f1, v1, h1}, 7'b0000101);
      prev1 = 3'b101;
      prev2 = 3'b101;
      embed_sel = 1'b1;
      push(8'h22);
      check("R7 hold after mode change", {c1, x1, e1, b1, f1, v1, h1}, {4'b0000, prev1});

      // random codes with 0 to 3 flipped bits, occasional bad MSB
      for (int n = 0; n < 300; n++) begin
         logic [7:0] st, mask;
         int ne;
         st   = mk_stat(3'($urandom));
         mask = 8'h00;
         ne   = $urandom % 4;
         for (int j = 0; j < ne; j++) mask[$urandom % 7] = 1'b1;
         if ($urandom % 16 == 0) mask[7] = 1'b1;
         for (int j = 0; j < int'($urandom % 3); j++) push(8'h01 + 8'($urandom % 254));
         send_code("R2 R3 R4 R5 R6 random", st ^ mask);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule